// File: doc/BRIEF.md
# Program Status Register Write Unit

This block keeps two 32-bit program status words, a live one and a banked copy, and carries out the two status-move operations of a processor core. A move-from-status returns whichever word the select input points at, in the same cycle. A move-to-status writes a source word into the selected register one byte lane at a time, under a four-bit lane mask. The source is either a general register value or an 8-bit immediate rotated into position.

Privilege limits what a write can reach. When the execution mode input shows user mode, or when the source is the immediate, only the top byte (the condition flags) can change. A separate flag-load port lets the arithmetic unit refresh the four condition flags of the live word. When that load and a status write land in the same cycle, the rule below decides which one wins.

Top module: `psr_write_unit`

## Requirements
- R1: After reset both words read 0x000000D3: mode field (bits 4:0) = 5'b10011, both interrupt-disable bits (7 and 6) set, and every other bit zero.
- R2: `rd_value` shows the live word when `sel_saved`=0 and the banked word when `sel_saved`=1, combinationally in the same cycle.
- R3: In a privileged mode with a register source, mask bit 0 writes bits 7:0, bit 1 writes bits 15:8, bit 2 writes bits 23:16 and bit 3 writes bits 31:24 on the clock edge after `wr_en`. Lanes whose mask bit is clear keep their value. Any combination of mask bits is allowed.
- R4: A write with `sel_saved`=0 changes only the live word, and a write with `sel_saved`=1 changes only the banked word.
- R5: When `exec_mode` equals 5'b10000 (user), a write changes at most bits 31:24. Mask bits 2:0 are ignored.
- R6: With `src_imm`=1 the source word is the zero-extended `imm_val` rotated right by twice `imm_rot`, and only bits 31:24 can change.
- R7: `flag_ld` loads `flag_in` = {N,Z,C,V} into bits 31:28 of the live word on the next edge and leaves bits 27:0 unchanged.
- R8: If a live-word write enables the flag lane in the same cycle as `flag_ld`, the write sets the whole of bits 31:24 and the flag load is lost. Otherwise both take effect.
- R9: With `wr_en`=0 and `flag_ld`=0 neither word changes, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_saved | input | 1 | 1 selects the banked word, 0 the live word, for both reading and writing |
| wr_en | input | 1 | Move-to-status strobe |
| field_mask | input | 4 | Byte-lane write enables, bit n covers bits 8n+7:8n |
| src_imm | input | 1 | 1 takes the rotated immediate as source, 0 takes `src_reg` |
| src_reg | input | 32 | Register source value |
| imm_val | input | 8 | Immediate byte |
| imm_rot | input | 4 | Rotate amount; the right rotation is twice this value |
| exec_mode | input | 5 | Current processor mode; 5'b10000 is user |
| flag_ld | input | 1 | Flag-load strobe from the arithmetic unit |
| flag_in | input | 4 | New flags {N,Z,C,V} |
| rd_value | output | 32 | Move-from-status result |
| cur_psr | output | 32 | Live status word |
| saved_psr | output | 32 | Banked status word |

## Verification
The flag load and a move-to-status aimed at the live word can arrive in the same cycle, and both may target the top byte. The bench raises `flag_ld` with a fresh flag nibble on a live-word write for each of the sixteen lane masks, in both privileged and user mode. It checks which of the two owns bits 31:28 against the lane mask that remains after privilege filtering. It also pairs a flag load with a write to the banked word and checks that the flags still land in the live word.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned PSR_W  = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = PSR_W / LANE_W;
  localparam int unsigned MODE_W = 5;
  localparam int unsigned ROT_W  = 4;
  localparam int unsigned IMM_W  = 8;
  localparam int unsigned FLAG_W = 4;

  localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_SVC  = 5'b10011;

  // supervisor mode, IRQ disable (bit 7) and FIQ disable (bit 6) set
  localparam logic [PSR_W-1:0] PSR_RESET = {{(PSR_W-8){1'b0}}, 2'b11, 1'b0, MODE_SVC};

  typedef logic [PSR_W-1:0] psr_word_t;
  typedef logic [LANES-1:0] lane_mask_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cond_flags_t;
endpackage

// File: rtl/psr_operand.sv
module psr_operand
  import psr_pkg::*;
#(
  parameter int unsigned W     = PSR_W,
  parameter int unsigned IW    = IMM_W,
  parameter int unsigned RW    = ROT_W
) (
  input  logic          use_imm,
  input  logic [W-1:0]  reg_val,
  input  logic [IW-1:0] imm,
  input  logic [RW-1:0] rot,
  output logic [W-1:0]  word
);
  // W must be a power of two so that index truncation wraps the rotation
  localparam int unsigned IDX_W = $clog2(W);

  logic [W-1:0]     ext;
  logic [W-1:0]     rot_word;
  logic [IDX_W-1:0] amt;

  always_comb begin
    ext = {{(W-IW){1'b0}}, imm};
    amt = IDX_W'({rot, 1'b0});
    for (int i = 0; i < int'(W); i++) begin
      rot_word[i] = ext[IDX_W'(i) + amt];
    end
  end

  assign word = use_imm ? rot_word : reg_val;
endmodule

// File: rtl/psr_lane_gate.sv
module psr_lane_gate
  import psr_pkg::*;
#(
  parameter int unsigned NL = LANES,
  parameter int unsigned MW = MODE_W
) (
  input  logic [NL-1:0] req_mask,
  input  logic [MW-1:0] mode,
  input  logic          use_imm,
  output logic [NL-1:0] lane_en
);
  localparam logic [NL-1:0] TOP_ONLY = {1'b1, {(NL-1){1'b0}}};

  logic          restricted;
  logic [NL-1:0] allowed;

  always_comb begin
    restricted = (mode == MW'(MODE_USER)) || use_imm;
    allowed    = restricted ? TOP_ONLY : {NL{1'b1}};
    lane_en    = req_mask & allowed;
  end
endmodule

// File: rtl/psr_bank.sv
module psr_bank
  import psr_pkg::*;
#(
  parameter int unsigned W  = PSR_W,
  parameter int unsigned LW = LANE_W,
  parameter int unsigned FW = FLAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_cur,
  input  logic             we_sav,
  input  logic [W/LW-1:0]  lane_en,
  input  logic [W-1:0]     wdata,
  input  logic             flag_ld,
  input  logic [FW-1:0]    flag_in,
  output logic [W-1:0]     cur_q,
  output logic [W-1:0]     sav_q
);
  localparam int unsigned NL  = W / LW;
  localparam int unsigned TOP = NL - 1;

  logic [W-1:0] cur_nxt;
  logic [W-1:0] sav_nxt;
  logic [W-1:0] cur_base;
  logic         cur_ce;
  logic         sav_ce;

  // flag load first, then any write lane replaces the whole byte
  always_comb begin
    cur_base = cur_q;
    if (flag_ld) cur_base[W-1 -: FW] = flag_in;
  end

  for (genvar l = 0; l < int'(NL); l++) begin : g_lane
    always_comb begin
      cur_nxt[l*LW +: LW] = (we_cur && lane_en[l]) ? wdata[l*LW +: LW] : cur_base[l*LW +: LW];
      sav_nxt[l*LW +: LW] = (we_sav && lane_en[l]) ? wdata[l*LW +: LW] : sav_q[l*LW +: LW];
    end
  end

  always_comb begin
    cur_ce = flag_ld || (we_cur && (|lane_en));
    sav_ce = we_sav && (|lane_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= W'(PSR_RESET);
    end else if (cur_ce) begin
      cur_q <= cur_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sav_q <= W'(PSR_RESET);
    end else if (sav_ce) begin
      sav_q <= sav_nxt;
    end
  end

  // flag load lands when no flag-lane write competes
  assert_flag_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ld && !(we_cur && lane_en[TOP])) |=> (cur_q[W-1 -: FW] == $past(flag_in)));

  // competing flag-lane write owns the top byte
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ld && we_cur && lane_en[TOP]) |=> (cur_q[W-1 -: LW] == $past(wdata[W-1 -: LW])));
endmodule

// File: rtl/psr_write_unit.sv
module psr_write_unit
  import psr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_saved,
  input  logic               wr_en,
  input  logic [LANES-1:0]   field_mask,
  input  logic               src_imm,
  input  logic [PSR_W-1:0]   src_reg,
  input  logic [IMM_W-1:0]   imm_val,
  input  logic [ROT_W-1:0]   imm_rot,
  input  logic [MODE_W-1:0]  exec_mode,
  input  logic               flag_ld,
  input  logic [FLAG_W-1:0]  flag_in,
  output logic [PSR_W-1:0]   rd_value,
  output logic [PSR_W-1:0]   cur_psr,
  output logic [PSR_W-1:0]   saved_psr
);
  localparam int unsigned LOW_W = PSR_W - LANE_W;

  logic        rst_meta_n;
  logic        rst_sync_n;
  psr_word_t   src_word;
  lane_mask_t  lane_en;
  logic        we_cur;
  logic        we_sav;
  cond_flags_t flags_new;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  psr_operand #(.W(PSR_W), .IW(IMM_W), .RW(ROT_W)) u_operand (
    .use_imm (src_imm),
    .reg_val (src_reg),
    .imm     (imm_val),
    .rot     (imm_rot),
    .word    (src_word)
  );

  psr_lane_gate #(.NL(LANES), .MW(MODE_W)) u_gate (
    .req_mask (field_mask),
    .mode     (exec_mode),
    .use_imm  (src_imm),
    .lane_en  (lane_en)
  );

  always_comb begin
    we_cur    = wr_en && !sel_saved;
    we_sav    = wr_en && sel_saved;
    flags_new = cond_flags_t'(flag_in);
  end

  psr_bank #(.W(PSR_W), .LW(LANE_W), .FW(FLAG_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_cur  (we_cur),
    .we_sav  (we_sav),
    .lane_en (lane_en),
    .wdata   (src_word),
    .flag_ld (flag_ld),
    .flag_in (flags_new),
    .cur_q   (cur_psr),
    .sav_q   (saved_psr)
  );

  assign rd_value = sel_saved ? saved_psr : cur_psr;

  assert_user_flag_only_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !sel_saved && exec_mode == MODE_USER) |=>
      (cur_psr[LOW_W-1:0] == $past(cur_psr[LOW_W-1:0])));

  assert_imm_flag_only_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && sel_saved && src_imm) |=>
      (saved_psr[LOW_W-1:0] == $past(saved_psr[LOW_W-1:0])));

  assert_live_write_isolation_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !sel_saved) |=> $stable(saved_psr));

  assert_banked_write_isolation_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && sel_saved && !flag_ld) |=> $stable(cur_psr));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_en && !flag_ld) |=> ($stable(cur_psr) && $stable(saved_psr)));
endmodule

// File: tb/psr_write_unit_test.sv
module psr_write_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_saved = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  field_mask = '0;
  logic        src_imm = 1'b0;
  logic [31:0] src_reg = '0;
  logic [7:0]  imm_val = '0;
  logic [3:0]  imm_rot = '0;
  logic [4:0]  exec_mode = 5'b10011;
  logic        flag_ld = 1'b0;
  logic [3:0]  flag_in = '0;
  logic [31:0] rd_value, cur_psr, saved_psr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] exp_cur, exp_sav;

  always #4 clk = ~clk;

  psr_write_unit uut (
    .clk(clk), .rst_n(rst_n), .sel_saved(sel_saved), .wr_en(wr_en),
    .field_mask(field_mask), .src_imm(src_imm), .src_reg(src_reg),
    .imm_val(imm_val), .imm_rot(imm_rot), .exec_mode(exec_mode),
    .flag_ld(flag_ld), .flag_in(flag_in), .rd_value(rd_value),
    .cur_psr(cur_psr), .saved_psr(saved_psr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ror_imm(input logic [7:0] v, input logic [3:0] r);
    logic [63:0] x;
    x = {24'd0, v, 24'd0, v};
    return 32'(x >> (2 * int'(r)));
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] m);
    logic [31:0] res;
    res = old;
    for (int b = 0; b < 4; b++) if (m[b]) res[b*8 +: 8] = d[b*8 +: 8];
    return res;
  endfunction

  // drive at negedge, one edge, sample at next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    flag_ld = 1'b0;
  endtask

  task automatic check_both(input string req);
    check(req, cur_psr, exp_cur);
    check(req, saved_psr, exp_sav);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_cur = 32'h000000D3;
    exp_sav = 32'h000000D3;
    check_both("R1 reset");
    sel_saved = 1'b0; #1 check("R2 read live", rd_value, exp_cur);
    sel_saved = 1'b1; #1 check("R2 read banked", rd_value, exp_sav);

    // sweep of select, privilege, source kind and lane mask (R3 R4 R5 R6)
    for (int k = 0; k < 128; k++) begin
      logic [31:0] word;
      logic [3:0]  eff;
      logic        usr, imm, sel;
      sel = k[6]; usr = k[5]; imm = k[4];
      sel_saved = sel;
      exec_mode = usr ? 5'b10000 : 5'b11111;
      src_imm = imm;
      field_mask = k[3:0];
      src_reg = 32'h9E3779B9 * (k + 1);
      imm_val = 8'(k * 37 + 5);
      imm_rot = 4'(k * 3);
      wr_en = 1'b1;
      word = imm ? ror_imm(imm_val, imm_rot) : src_reg;
      eff = field_mask & ((usr || imm) ? 4'b1000 : 4'b1111);
      if (sel) exp_sav = merge(exp_sav, word, eff);
      else     exp_cur = merge(exp_cur, word, eff);
      step();
      if (imm)      check_both("R6 immediate flag-only write");
      else if (usr) check_both("R5 user flag-only write");
      else          check_both("R3 lane write / R4 select");
      sel_saved = ~sel; #1
      check("R2 read other word", rd_value, sel ? exp_cur : exp_sav);
    end

    // rotate sweep into the flag byte and low byte (R6)
    exec_mode = 5'b10011;
    for (int r = 0; r < 16; r++) begin
      sel_saved = 1'b0; src_imm = 1'b1; field_mask = 4'hF;
      imm_val = 8'hA5; imm_rot = 4'(r); wr_en = 1'b1;
      exp_cur = merge(exp_cur, ror_imm(8'hA5, 4'(r)), 4'b1000);
      step();
      check("R6 rotate", cur_psr, exp_cur);
    end

    // flag load alone (R7)
    for (int f = 0; f < 16; f++) begin
      flag_ld = 1'b1; flag_in = 4'(f);
      exp_cur = {4'(f), exp_cur[27:0]};
      step();
      check_both("R7 flag load");
    end

    // collisions of flag load and write (R8)
    for (int k = 0; k < 32; k++) begin
      logic [3:0] eff;
      logic       usr;
      usr = k[4];
      exec_mode = usr ? 5'b10000 : 5'b10011;
      sel_saved = 1'b0; src_imm = 1'b0; field_mask = k[3:0];
      src_reg = 32'h5A000000 ^ (32'h01010101 * (k + 3));
      flag_ld = 1'b1; flag_in = 4'(~k);
      wr_en = 1'b1;
      eff = field_mask & (usr ? 4'b1000 : 4'b1111);
      exp_cur = {4'(~k), exp_cur[27:0]};
      exp_cur = merge(exp_cur, src_reg, eff);
      step();
      check_both("R8 flag load vs live write");
    end
    exec_mode = 5'b10011;
    sel_saved = 1'b1; src_imm = 1'b0; field_mask = 4'hF;
    src_reg = 32'h13579BDF; flag_ld = 1'b1; flag_in = 4'b0110; wr_en = 1'b1;
    exp_sav = src_reg;
    exp_cur = {4'b0110, exp_cur[27:0]};
    step();
    check_both("R8 flag load vs banked write");

    // idle inputs toggling (R9)
    for (int k = 0; k < 8; k++) begin
      sel_saved = k[0]; field_mask = 4'hF; src_reg = ~32'(k); src_imm = k[1];
      flag_in = 4'(k);
      @(posedge clk); @(negedge clk);
      check_both("R9 idle hold");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule